// File: doc/BRIEF.md
# Four-bit dual-mode storage latch

The block holds four independent bits, each with its own data input, its own active-low set input and its own output. All four bits share one active-low gate and one active-low clear. A bit's role is chosen by how its set and data inputs are driven. With set held low, the bit is a transparent data latch. With set used as a control, the bit is a set/reset latch in which data wins over set.

The block is a clocked emulation of a level-sensitive latch. It samples its inputs on every rising clock edge and updates its outputs there. The clear acts at once, without waiting for a clock edge. While the gate is inactive, nothing on the data or set pins reaches the stored value. The clear overrides everything else.

Top module: `quad_mode_latch`

## Requirements
- R1: While clear_n is 0, every bit of dout is 0 at once (asynchronously) and stays 0, whatever gate_n, din and pre_n are.
- R2: At a rising clock edge with clear_n = 1 and gate_n = 1, every bit of dout keeps its value, and din and pre_n have no effect.
- R3: At a rising clock edge with gate_n = 0 and pre_n[i] = 0, dout[i] takes the value of din[i] (transparent mode).
- R4: At a rising clock edge with gate_n = 0, pre_n[i] = 1 and din[i] = 0, dout[i] becomes 0 (reset).
- R5: At a rising clock edge with gate_n = 0, pre_n[i] = 0 and din[i] = 1, dout[i] becomes 1 (set).
- R6: At a rising clock edge with gate_n = 0 and both pre_n[i] = 0 and din[i] = 0, dout[i] becomes 0 (data dominates set).
- R7: At a rising clock edge with gate_n = 0, pre_n[i] = 1 and din[i] = 1, dout[i] keeps its value.
- R8: After clear_n returns to 1 while gate_n = 1, dout stays 0 until an edge with gate_n = 0.
- R9: Each bit's next value depends only on its own din and pre_n bits, so the four bits may be in different modes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| clear_n | input | 1 | Asynchronous active-low clear of all bits |
| gate_n | input | 1 | Active-low common gate |
| din | input | 4 | Per-bit data inputs |
| pre_n | input | 4 | Per-bit active-low set inputs |
| dout | output | 4 | Stored bit values |

## Verification
A wrong stored bit appears directly on dout. The output is the stored state, so any fault shows one edge after the stimulus that caused it. A fault in the hold path shows up only after a later gated-off or both-high cycle, because that is when the bit should have kept its value. The bench therefore compares every cycle and interleaves hold cycles with mode changes. This lets a stale or lost value be seen within one clock.

// File: rtl/quad_mode_latch.sv
module quad_mode_latch #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             gate_n,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] pre_n,
  output logic [WIDTH-1:0] dout
);

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      logic nxt;
      assign nxt = din[i] & (~pre_n[i] | dout[i]);

      always_ff @(posedge clk or negedge clear_n)
        if (!clear_n)     dout[i] <= 1'b0;
        else if (!gate_n) dout[i] <= nxt;

      // R4
      a_r4_reset: assert property (@(posedge clk) disable iff (!clear_n)
        (!gate_n && pre_n[i] && !din[i]) |=> !dout[i]);
      // R5
      a_r5_set: assert property (@(posedge clk) disable iff (!clear_n)
        (!gate_n && !pre_n[i] && din[i]) |=> dout[i]);
      // R6
      a_r6_data_wins: assert property (@(posedge clk) disable iff (!clear_n)
        (!gate_n && !pre_n[i] && !din[i]) |=> !dout[i]);
      // R7
      a_r7_keep: assert property (@(posedge clk) disable iff (!clear_n)
        (!gate_n && pre_n[i] && din[i]) |=> $stable(dout[i]));
    end
  endgenerate

  // R1
  a_r1_clear: assert property (@(posedge clk) !clear_n |-> dout == '0);
  // R2
  a_r2_hold: assert property (@(posedge clk) disable iff (!clear_n)
    gate_n |=> $stable(dout));

endmodule

// File: tb/quad_mode_latch_tb.sv
module quad_mode_latch_tb;
  logic clk = 0;
  logic clear_n = 0, gate_n = 1;
  logic [3:0] din = 0, pre_n = 0;
  logic [3:0] dout;
  logic [3:0] model = 0;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  quad_mode_latch #(.WIDTH(4)) u_dut (
    .clk(clk), .clear_n(clear_n), .gate_n(gate_n),
    .din(din), .pre_n(pre_n), .dout(dout));

  always @(posedge clk or negedge clear_n) begin
    if (!clear_n) model <= 4'h0;
    else if (!gate_n)
      for (int b = 0; b < 4; b++) begin
        case ({pre_n[b], din[b]})
          2'b00: model[b] <= 1'b0;
          2'b01: model[b] <= 1'b1;
          2'b10: model[b] <= 1'b0;
          default: model[b] <= model[b];
        endcase
      end
  end

  task automatic check(input string tag, input logic [3:0] exp);
    total++;
    if (dout !== exp) begin
      bad++;
      $display("FAIL %s dout=%h expected=%h", tag, dout, exp);
    end
  endtask

  task automatic step(input string tag, input logic c, input logic g,
                      input logic [3:0] d, input logic [3:0] p);
    @(negedge clk);
    clear_n = c; gate_n = g; din = d; pre_n = p;
    @(negedge clk);
    check(tag, model);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog dout=%h expected=%h", dout, model);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset state", 4'h0);
    step("R3 follow", 1, 0, 4'hA, 4'h0);  check("R3 value", 4'hA);
    step("R3 follow", 1, 0, 4'h5, 4'h0);  check("R3 value", 4'h5);
    step("R2 hold", 1, 1, 4'hA, 4'h0);    check("R2 value", 4'h5);
    step("R2 hold", 1, 1, 4'h0, 4'hF);    check("R2 value", 4'h5);
    step("R5 set", 1, 0, 4'hF, 4'h0);     check("R5 value", 4'hF);
    step("R7 keep", 1, 0, 4'hF, 4'hF);    check("R7 value", 4'hF);
    step("R4 reset", 1, 0, 4'hC, 4'hF);   check("R4 value", 4'hC);
    step("R7 keep", 1, 0, 4'hF, 4'hF);    check("R7 value", 4'hC);
    step("R6 data wins", 1, 0, 4'h3, 4'h0); check("R6 value", 4'h3);
    step("R6 data wins", 1, 0, 4'h0, 4'h0); check("R6 value", 4'h0);
    step("R9 mixed", 1, 0, 4'b1101, 4'b0110); check("R9 value", 4'b1001);
    step("R9 mixed", 1, 0, 4'b0111, 4'b1100); check("R9 value", 4'b0011);
    step("R5 set", 1, 0, 4'hF, 4'h0);
    @(negedge clk); #3 clear_n = 0; gate_n = 0; din = 4'hF; pre_n = 4'h0;
    #2 check("R1 async clear", 4'h0);
    @(negedge clk); check("R1 held", 4'h0);
    step("R8 release gated off", 1, 1, 4'hF, 4'h0); check("R8 value", 4'h0);
    step("R8 still zero", 1, 1, 4'hF, 4'h0);       check("R8 value", 4'h0);
    step("R8 gate on", 1, 0, 4'h6, 4'h0);          check("R8 value", 4'h6);
    for (int k = 0; k < 300; k++)
      step("R9 random", ($urandom % 16) != 0, $urandom % 2,
           4'($urandom), 4'($urandom));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule